// File: doc/BRIEF.md
# Bit-Plane Multi-Width Vector Shifter

This block shifts or rotates every element of a wide vector by one common amount. The vector is a row of byte lanes, and a width code groups the lanes into elements of one, two or four lanes (8, 16 or 32 bits with the default lane width). Each element moves on its own and no bit ever crosses into a neighbouring element. The supported operations are logical shift left and right, arithmetic shift right, and rotate left and right.

The block has no per-element barrel shifter. The input is first transposed into bit-plane words, each holding the same element bit from eight different elements. A shift by `s` then becomes a move of whole plane words by `s` positions, which one lane-wide crossbar carries out. Vacated planes are either forced to zero or, for an arithmetic right shift, taken from the sign plane. The inverse transpose then puts the bits back into element order.

The block is a two-stage pipeline. Stage one registers the transposed planes and the crossbar routing. Stage two registers the crossbar output after the inverse transpose. A new vector can be accepted on every clock cycle.

Top module: `xshf_top`

## Requirements
- R1: When `in_valid` is high in clock cycle c, `out_valid` is high in cycle c+2 and carries the result for that input. `out_valid` is low in any cycle whose input two cycles earlier was not valid.
- R2: While `out_valid` is low, `out_data` keeps the last result it showed.
- R3: Logical shift (`in_op` = 0) moves every bit of each element by the effective amount, left when `in_right` = 0 and right when `in_right` = 1. Vacated positions fill with zero, and nothing crosses an element boundary.
- R4: Arithmetic shift (`in_op` = 1) to the right fills vacated positions with the element's own most significant bit. To the left it behaves exactly like a logical left shift.
- R5: Rotate (`in_op` = 2) moves bits that leave one end of an element back in at the other end of the same element, in the direction set by `in_right`.
- R6: The width code `in_width` selects the element size: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 give 32 bits.
- R7: The effective amount is `in_amount` modulo the element width, so bits of the amount at or above log2(width) have no effect. An effective amount of 0 returns the input unchanged, whatever the operation.
- R8: While `rst` is high at a rising edge, `out_valid` and `out_data` are cleared to zero at that edge.
- R9: Inputs on consecutive cycles, each with its own width, operation, direction and amount, each produce their own correct result on consecutive cycles.
- R10: Operation code 3 behaves exactly like rotate (code 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The input vector and its controls are valid this cycle |
| in_data | input | NUM_LANES*LANE_W | Vector to shift |
| in_width | input | 2 | Element width code: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits |
| in_op | input | 2 | Operation: 0 logical, 1 arithmetic, 2 or 3 rotate |
| in_right | input | 1 | Direction: 0 left (toward the MSB), 1 right |
| in_amount | input | log2(4*LANE_W) | Shift amount, taken modulo the element width |
| out_valid | output | 1 | `out_data` carries a new result |
| out_data | output | NUM_LANES*LANE_W | Shifted vector |

## Verification
The bench builds the block with its default parameters: 32 lanes of 8 bits. This gives the full 256-bit vector, so all three element widths can be reached, along with every effective amount up to 31 and amounts whose upper bits must be dropped. With these values, word routing across four, two and one element groups is exercised, as are sign-plane fill and wraparound at each element boundary. A back-to-back stream with mixed controls shows that the two pipeline stages keep the settings of each input apart.

// File: rtl/xshf_pkg.sv
package xshf_pkg;

    // Element width code; code 3 aliases the widest element.
    typedef enum logic [1:0] {
        EW_8   = 2'd0,
        EW_16  = 2'd1,
        EW_32  = 2'd2,
        EW_32B = 2'd3
    } ewidth_e;

    // Shift operation code; code 3 aliases rotate.
    typedef enum logic [1:0] {
        SOP_LOGIC = 2'd0,
        SOP_ARITH = 2'd1,
        SOP_ROT   = 2'd2,
        SOP_ROT2  = 2'd3
    } sop_e;

    typedef struct packed {
        ewidth_e width;
        sop_e    op;
        logic    right;
    } shctl_t;

    // Crossbar routing for one plane word.
    typedef struct packed {
        logic        zero;
        logic [15:0] src;
    } route_t;

    localparam int unsigned NUM_WIDTHS = 3;

    // log2 of (element width / lane width)
    function automatic int unsigned width_step(ewidth_e w);
        case (w)
            EW_8:    return 0;
            EW_16:   return 1;
            default: return 2;
        endcase
    endfunction

    function automatic logic op_wraps(sop_e op);
        return (op == SOP_ROT) || (op == SOP_ROT2);
    endfunction

    // Plane word index = element_bit * groups + group.
    // A shift moves whole plane words inside one group.
    function automatic route_t plane_route(int unsigned word, int unsigned lg_w,
                                           int unsigned lg_g, int unsigned amount,
                                           logic right, sop_e op);
        route_t      r;
        int unsigned wbits;
        int unsigned q;
        int unsigned g;
        int unsigned s;
        int unsigned sq;
        wbits  = 32'd1 << lg_w;
        q      = word >> lg_g;
        g      = word & ((32'd1 << lg_g) - 32'd1);
        s      = amount & (wbits - 32'd1);
        sq     = 0;
        r.zero = 1'b0;
        if (!right) begin
            if (q >= s)            sq = q - s;
            else if (op_wraps(op)) sq = q + wbits - s;
            else                   r.zero = 1'b1;
        end else begin
            if (q + s < wbits)        sq = q + s;
            else if (op_wraps(op))    sq = q + s - wbits;
            else if (op == SOP_ARITH) sq = wbits - 32'd1;
            else                      r.zero = 1'b1;
        end
        r.src = 16'((sq << lg_g) | g);
        return r;
    endfunction

endpackage

// File: rtl/xshf_transpose.sv
// Bit-plane transpose (INVERSE = 0) or its inverse (INVERSE = 1).
// Every element width gets its own fixed wiring; the width code picks one.
module xshf_transpose
    import xshf_pkg::*;
#(
    parameter int unsigned NUM_LANES = 32,
    parameter int unsigned LANE_W    = 8,
    parameter bit          INVERSE   = 1'b0,
    localparam int unsigned DATA_W   = NUM_LANES * LANE_W
) (
    input  logic [DATA_W-1:0] din,
    input  ewidth_e           width,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] cand [NUM_WIDTHS];
    logic [1:0]        pick;

    for (genvar m = 0; m < NUM_WIDTHS; m++) begin : g_mode
        localparam int unsigned EW  = LANE_W << m;
        localparam int unsigned GRP = NUM_LANES / EW;
        logic [DATA_W-1:0] vec;
        for (genvar w = 0; w < NUM_LANES; w++) begin : g_word
            for (genvar i = 0; i < LANE_W; i++) begin : g_bit
                localparam int unsigned P = w * LANE_W + i;
                if (!INVERSE) begin : g_fwd
                    // plane word w, bit i <- element (grp*LANE_W+i), bit q
                    localparam int unsigned Q   = w / GRP;
                    localparam int unsigned GI  = w % GRP;
                    localparam int unsigned SRC = (GI * LANE_W + i) * EW + Q;
                    assign vec[P] = din[SRC];
                end else begin : g_inv
                    // flat bit P <- plane word of (element bit, group), lane bit
                    localparam int unsigned E   = P / EW;
                    localparam int unsigned Q   = P % EW;
                    localparam int unsigned GI  = E / LANE_W;
                    localparam int unsigned LI  = E % LANE_W;
                    localparam int unsigned SRC = (Q * GRP + GI) * LANE_W + LI;
                    assign vec[P] = din[SRC];
                end
            end
        end
        assign cand[m] = vec;
    end

    always_comb begin
        pick = 2'(width_step(width));
        dout = cand[pick];
    end

endmodule

// File: rtl/xshf_route.sv
// Computes, for every plane word, which input plane feeds it or whether it is forced to zero.
module xshf_route
    import xshf_pkg::*;
#(
    parameter int unsigned NUM_LANES = 32,
    parameter int unsigned LANE_W    = 8,
    localparam int unsigned LIDX_W   = $clog2(NUM_LANES),
    localparam int unsigned AMT_W    = $clog2(4 * LANE_W),
    localparam int unsigned LOG_LANE = $clog2(LANE_W),
    localparam int unsigned LOG_NUM  = $clog2(NUM_LANES)
) (
    input  shctl_t                            ctl,
    input  logic [AMT_W-1:0]                  amount,
    output logic [NUM_LANES-1:0][LIDX_W-1:0]  sel,
    output logic [NUM_LANES-1:0]              zero
);

    int unsigned lg_w;
    int unsigned lg_g;

    always_comb begin
        route_t r;
        lg_w = LOG_LANE + width_step(ctl.width);
        lg_g = LOG_NUM - lg_w;
        for (int w = 0; w < NUM_LANES; w++) begin
            r       = plane_route(32'(w), lg_w, lg_g, 32'(amount), ctl.right, ctl.op);
            sel[w]  = r.src[LIDX_W-1:0];
            zero[w] = r.zero;
        end
    end

endmodule

// File: rtl/xshf_xbar.sv
// Any-to-any crossbar of lane-wide words, with a per-output force-to-zero.
module xshf_xbar #(
    parameter int unsigned NUM_LANES = 32,
    parameter int unsigned LANE_W    = 8,
    localparam int unsigned LIDX_W   = $clog2(NUM_LANES),
    localparam int unsigned DATA_W   = NUM_LANES * LANE_W
) (
    input  logic [DATA_W-1:0]                 din,
    input  logic [NUM_LANES-1:0][LIDX_W-1:0]  sel,
    input  logic [NUM_LANES-1:0]              zero,
    output logic [DATA_W-1:0]                 dout
);

    logic [NUM_LANES-1:0][LANE_W-1:0] words;
    assign words = din;

    for (genvar w = 0; w < NUM_LANES; w++) begin : g_out
        assign dout[w*LANE_W +: LANE_W] = zero[w] ? '0 : words[sel[w]];
    end

endmodule

// File: rtl/xshf_top.sv
module xshf_top
    import xshf_pkg::*;
#(
    parameter int unsigned NUM_LANES = 32,
    parameter int unsigned LANE_W    = 8,
    localparam int unsigned DATA_W   = NUM_LANES * LANE_W,
    localparam int unsigned AMT_W    = $clog2(4 * LANE_W),
    localparam int unsigned LIDX_W   = $clog2(NUM_LANES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [1:0]        in_width,
    input  logic [1:0]        in_op,
    input  logic              in_right,
    input  logic [AMT_W-1:0]  in_amount,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    shctl_t                            ctl;
    logic [DATA_W-1:0]                 planes_c;
    logic [NUM_LANES-1:0][LIDX_W-1:0]  sel_c;
    logic [NUM_LANES-1:0]              zero_c;

    // stage one registers
    logic                              s1_valid;
    logic [DATA_W-1:0]                 s1_planes;
    logic [NUM_LANES-1:0][LIDX_W-1:0]  s1_sel;
    logic [NUM_LANES-1:0]              s1_zero;
    ewidth_e                           s1_width;

    logic [DATA_W-1:0]                 moved_c;
    logic [DATA_W-1:0]                 result_c;

    assign ctl = '{width: ewidth_e'(in_width), op: sop_e'(in_op), right: in_right};

    xshf_transpose #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W), .INVERSE(1'b0)) u_scramble (
        .din   (in_data),
        .width (ctl.width),
        .dout  (planes_c)
    );

    xshf_route #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_route (
        .ctl    (ctl),
        .amount (in_amount),
        .sel    (sel_c),
        .zero   (zero_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid  <= 1'b0;
            s1_planes <= '0;
            s1_sel    <= '0;
            s1_zero   <= '0;
            s1_width  <= EW_8;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_planes <= planes_c;
                s1_sel    <= sel_c;
                s1_zero   <= zero_c;
                s1_width  <= ctl.width;
            end
        end
    end

    xshf_xbar #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_xbar (
        .din  (s1_planes),
        .sel  (s1_sel),
        .zero (s1_zero),
        .dout (moved_c)
    );

    xshf_transpose #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W), .INVERSE(1'b1)) u_descramble (
        .din   (moved_c),
        .width (s1_width),
        .dout  (result_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) out_data <= result_c;
        end
    end

endmodule

// File: rtl/xshf_chk.sv
module xshf_chk #(
    parameter int unsigned DATA_W = 256,
    parameter int unsigned LANE_W = 8,
    parameter int unsigned AMT_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic [1:0]        in_width,
    input logic [1:0]        in_op,
    input logic              in_right,
    input logic [AMT_W-1:0]  in_amount,
    input logic              s1_valid,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);

    logic [AMT_W-1:0] amt_mask;
    logic [AMT_W-1:0] eff_amt;

    always_comb begin
        case (in_width)
            2'd0:    amt_mask = AMT_W'(LANE_W - 1);
            2'd1:    amt_mask = AMT_W'(2 * LANE_W - 1);
            default: amt_mask = AMT_W'(4 * LANE_W - 1);
        endcase
        eff_amt = in_amount & amt_mask;
    end

    // R1: valid travels through both stages
    p_stage_fill_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> s1_valid);
    p_stage_drain_r1: assert property (@(posedge clk) disable iff (rst)
        s1_valid |=> out_valid);
    p_no_spurious_r1: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> !out_valid);

    // R2: result register holds when nothing new arrives
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> $stable(out_data));

    // R3: a nonzero left shift without wrap clears the lowest vector bit
    p_left_lsb_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_right && !in_op[1] && eff_amt != '0) |=> ##1 !out_data[0]);

    // R4: arithmetic right keeps the top element's sign bit
    p_sign_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_right && in_op == 2'd1) |=> ##1
            (out_data[DATA_W-1] == $past(in_data[DATA_W-1], 2)));

    // R5: rotation preserves the number of set bits
    p_rot_ones_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op[1]) |=> ##1
            ($countones(out_data) == $countones($past(in_data, 2))));

    // R7: zero effective amount is a pass-through
    p_zero_amt_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && eff_amt == '0) |=> ##1 (out_data == $past(in_data, 2)));

    // R8: reset clears the output
    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

endmodule

bind xshf_top xshf_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W), .AMT_W(AMT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_width  (in_width),
    .in_op     (in_op),
    .in_right  (in_right),
    .in_amount (in_amount),
    .s1_valid  (s1_valid),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/sim_xshf_top.sv
module sim_xshf_top;

    localparam int N = 256;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [N-1:0] in_data = '0;
    logic [1:0]   in_width = 2'd0;
    logic [1:0]   in_op = 2'd0;
    logic         in_right = 1'b0;
    logic [4:0]   in_amount = 5'd0;
    logic         out_valid;
    logic [N-1:0] out_data;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    xshf_top u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_width  (in_width),
        .in_op     (in_op),
        .in_right  (in_right),
        .in_amount (in_amount),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // Element-wise model written from the requirements.
    function automatic logic [N-1:0] model(logic [N-1:0] d, int wsel, int op, bit right, int amt);
        logic [N-1:0] r;
        int  ew;
        int  s;
        int  base;
        bit  rot;
        bit  ar;
        logic b;
        ew  = (wsel == 0) ? 8 : (wsel == 1) ? 16 : 32;
        s   = amt % ew;
        rot = (op >= 2);
        ar  = (op == 1);
        r   = '0;
        for (int e = 0; e < N / ew; e++) begin
            base = e * ew;
            for (int q = 0; q < ew; q++) begin
                if (!right) begin
                    if (q >= s)   b = d[base + q - s];
                    else if (rot) b = d[base + q - s + ew];
                    else          b = 1'b0;
                end else begin
                    if (q + s < ew) b = d[base + q + s];
                    else if (rot)   b = d[base + q + s - ew];
                    else if (ar)    b = d[base + ew - 1];
                    else            b = 1'b0;
                end
                r[base + q] = b;
            end
        end
        return r;
    endfunction

    function automatic logic [N-1:0] pattern(int k);
        logic [N-1:0] p;
        for (int i = 0; i < 8; i++)
            p[i*32 +: 32] = (32'h9E3779B9 * (k + 1)) ^ (32'h7F4A7C15 * i) ^ {i[7:0], 24'h5A00C3};
        return p;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_expect(input logic [N-1:0] d, input int w, input int op, input bit right,
                              input int amt, input logic [N-1:0] exp, input string req);
        @(negedge clk);
        in_data = d; in_width = 2'(w); in_op = 2'(op); in_right = right;
        in_amount = 5'(amt); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b0, {req, " R1 not yet valid"}, N'(out_valid), N'(0));
        @(negedge clk);
        chk(out_valid == 1'b1, {req, " R1 valid after two cycles"}, N'(out_valid), N'(1));
        chk(out_data == exp, req, out_data, exp);
    endtask

    task automatic run_case(input logic [N-1:0] d, input int w, input int op, input bit right,
                            input int amt, input string req);
        run_expect(d, w, op, right, amt, model(d, w, op, right, amt), req);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R8 reset valid", N'(out_valid), N'(0));
        chk(out_data == '0, "R8 reset data", out_data, '0);
        rst = 1'b0;
    endtask

    task automatic t_logical();
        run_expect({8{32'h11223344}}, 2, 0, 1'b0, 8, {8{32'h22334400}}, "R3 logical left 32 by 8");
        for (int w = 0; w < 3; w++) begin
            run_case(pattern(w), w, 0, 1'b0, 3, "R3 logical left");
            run_case(pattern(w + 3), w, 0, 1'b1, 5, "R3 logical right");
        end
        run_case(pattern(9), 1, 0, 1'b1, 15, "R3 logical right max amount");
    endtask

    task automatic t_arith();
        run_expect({32{8'h80}}, 0, 1, 1'b1, 1, {32{8'hC0}}, "R4 arith right 8 by 1");
        run_expect({16{16'h4000}}, 1, 1, 1'b1, 1, {16{16'h2000}}, "R4 arith right positive");
        for (int w = 0; w < 3; w++)
            run_case(pattern(10 + w) | {N/8{8'h80}}, w, 1, 1'b1, 3, "R4 arith right sign fill");
        run_case(pattern(14), 2, 1, 1'b0, 7, "R4 arith left equals logical");
        run_expect(pattern(14), 2, 1, 1'b0, 7, model(pattern(14), 2, 0, 1'b0, 7), "R4 arith left vs logical");
        run_case(pattern(15), 2, 1, 1'b1, 31, "R4 arith right 32 by 31");
    endtask

    task automatic t_rotate();
        run_expect({16{16'h1234}}, 1, 2, 1'b0, 4, {16{16'h2341}}, "R5 rotate left 16 by 4");
        run_expect({32{8'h81}}, 0, 2, 1'b1, 1, {32{8'hC0}}, "R5 rotate right 8 by 1");
        for (int w = 0; w < 3; w++) begin
            run_case(pattern(20 + w), w, 2, 1'b0, 5, "R5 rotate left");
            run_case(pattern(23 + w), w, 2, 1'b1, 7, "R5 rotate right");
        end
    endtask

    task automatic t_width_code();
        run_case(pattern(30), 3, 0, 1'b0, 9, "R6 width code 3 as 32");
        run_expect(pattern(31), 3, 2, 1'b1, 13, model(pattern(31), 2, 2, 1'b1, 13), "R6 width code 3 rotate");
        run_expect({8{32'h000000FF}}, 1, 0, 1'b0, 4, {8{32'h00000FF0}}, "R6 width 16 boundary");
        run_expect({8{32'h0000FF00}}, 0, 0, 1'b0, 4, {8{32'h0000F000}}, "R6 width 8 boundary");
    endtask

    task automatic t_amount();
        run_expect(pattern(40), 0, 0, 1'b0, 0, pattern(40), "R7 zero amount logical");
        run_expect(pattern(41), 1, 1, 1'b1, 16, pattern(41), "R7 amount 16 at width 16 is zero");
        run_expect(pattern(42), 0, 2, 1'b0, 11, model(pattern(42), 0, 2, 1'b0, 3), "R7 amount 11 at width 8 is 3");
        run_case(pattern(43), 0, 0, 1'b1, 7, "R7 amount width-1");
    endtask

    task automatic t_op3();
        run_expect(pattern(50), 0, 3, 1'b0, 2, model(pattern(50), 0, 2, 1'b0, 2), "R10 op 3 rotate left");
        run_expect(pattern(51), 2, 3, 1'b1, 17, model(pattern(51), 2, 2, 1'b1, 17), "R10 op 3 rotate right");
    endtask

    task automatic t_hold();
        logic [N-1:0] last;
        run_case(pattern(60), 1, 0, 1'b0, 6, "R2 setup");
        last = out_data;
        repeat (2) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R2 idle valid low", N'(out_valid), N'(0));
            chk(out_data == last, "R2 data held", out_data, last);
        end
    endtask

    task automatic t_stream();
        logic [N-1:0] expv [8];
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (k >= 2) begin
                chk(out_valid == 1'b1, "R9 stream valid", N'(out_valid), N'(1));
                chk(out_data == expv[k-2], "R9 stream data", out_data, expv[k-2]);
            end
            in_data = pattern(70 + k); in_width = 2'(k % 3); in_op = 2'(k % 4);
            in_right = k[0]; in_amount = 5'(3 * k + 1); in_valid = 1'b1;
            expv[k] = model(pattern(70 + k), k % 3, k % 4, k[0], 3 * k + 1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_data == expv[6], "R9 stream data tail", out_data, expv[6]);
        @(negedge clk);
        chk(out_data == expv[7], "R9 stream data last", out_data, expv[7]);
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 stream drained", N'(out_valid), N'(0));
    endtask

    task automatic t_reset_mid();
        run_case(pattern(80), 2, 2, 1'b0, 3, "R8 setup");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R8 mid reset valid", N'(out_valid), N'(0));
        chk(out_data == '0, "R8 mid reset data", out_data, '0);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        t_reset();
        t_logical();
        t_arith();
        t_rotate();
        t_width_code();
        t_amount();
        t_op3();
        t_hold();
        t_stream();
        t_reset_mid();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

endmodule